// File: doc/BRIEF.md
# HDLC Frame Receiver with Tagged Receive Queue

This block recovers HDLC packets from a serial bit stream. A bit is taken on each clock cycle where the bit-enable input is high, so the line rate can be any fraction of the clock. The receiver looks for the 7E flag and starts a packet only after a flag. It drops the zero that a transmitter inserts after five ones, and builds bytes least significant bit first. It checks the 16-bit frame check sequence and can drop packets whose first byte does not match a configured address. It also flags a run of seven ones that follows a flag directly, which is the go-ahead pattern.

Each data byte goes into a receive queue with a two-bit tag, so a reader sees where each packet starts and ends and whether its check sequence was correct. The two check-sequence bytes are not stored. Their result travels on the tag of the last data byte. The queue is read through a valid/ready port. A word stays on the outputs until it is taken in a cycle where `rd_valid` and `rd_ready` are both high. Holding `rd_ready` low stalls the reader only. The line side is never stalled. When the queue is full, the rest of the current packet is dropped and reported.

Top module: `hdlc_rx_tagq`

## Requirements
- R1: After reset, and after an abort, no word enters the queue until a 7E flag has been seen. Bits that arrive before that flag are discarded.
- R2: A 0 that follows five consecutive 1 data bits is removed. Data bytes whose bit stream needs such zeros come out unchanged.
- R3: Each stored word is an 8-bit data byte plus a 2-bit tag. Tag 01 marks the first byte of a packet and tag 00 marks a middle byte.
- R4: The last two bytes before the closing flag are taken as the check sequence and are not stored. The CRC uses polynomial x^16+x^12+x^5+1, bit-reflected, with a preset of FFFF. The check sequence is sent complemented, low byte first. When the check passes, the last data byte gets tag 10. A packet with a single data byte carries tag 10 on that byte alone.
- R5: The last data byte gets tag 11 in three cases: the check fails, the packet holds fewer than three bytes, or the packet does not end on a byte boundary.
- R6: Seven consecutive 1 bits inside a packet end it as aborted. The oldest byte not yet stored is written with tag 11, and the receiver then hunts for a flag (R1).
- R7: Seven consecutive 1 bits that start right after a flag's closing 0 cause a one-cycle pulse on `ga_pulse`.
- R8: While `cfg_addr_en` is 1, a packet whose first byte differs from `cfg_addr` leaves nothing in the queue. When the byte matches, the whole packet is stored.
- R9: If a word would be written while the queue is full, `irq_ovf` pulses for one cycle and no later word of that packet is stored. The next packet is stored normally.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` and `rd_stat` hold their values.
- R11: `irq_pkt` pulses for one cycle for each word with tag 10 or 11 that enters the queue.
- R12: After reset, `rd_valid`, `irq_pkt`, `irq_ovf` and `ga_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial line bit |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| cfg_addr_en | input | 1 | Enables the first-byte address filter |
| cfg_addr | input | 8 | Address a packet's first byte must equal |
| rd_valid | output | 1 | A queue word is on `rd_data`/`rd_stat` |
| rd_ready | input | 1 | Reader takes the word when high with `rd_valid` |
| rd_data | output | 8 | Data byte of the head word |
| rd_stat | output | 2 | Tag of the head word: 00 middle, 01 first, 10 good last, 11 bad last |
| irq_pkt | output | 1 | Pulse when a packet-ending word is stored |
| irq_ovf | output | 1 | Pulse when a write meets a full queue |
| ga_pulse | output | 1 | Pulse on a go-ahead pattern |

## Verification
Packets of one, two, three, four, five and six data bytes are sent with correct and with corrupted check sequences. Comparing the tags separates first, middle and last handling from the outcome of the check. Bytes full of ones force zero insertion, so a destuffing fault shows up in the data. Directed sequences cover an abort in mid-packet, a closing flag off a byte boundary, bits sent before any flag, a go-ahead after a flag, a matching and a non-matching address, and a packet longer than the queue. Each case tells a tag, drop or pulse fault apart from a plain data error.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W   = 8;
  localparam int TAG_W    = 2;
  localparam int WORD_W   = BYTE_W + TAG_W;
  localparam int FLAG_DLY = 7;   // flag bits that reach the data path before the flag is known
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RF = 16'h8408;
  localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

  typedef enum logic [1:0] {
    TAG_MID   = 2'b00,
    TAG_FIRST = 2'b01,
    TAG_GOOD  = 2'b10,
    TAG_BAD   = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    K_NONE, K_PUSH, K_FLAG, K_ABORT
  } bit_kind_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_RF;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_en,
  output logic              ev_byte,
  output logic [BYTE_W-1:0] ev_data,
  output logic              ev_flag,
  output logic              ev_misalign,
  output logic              ev_abort,
  output logic              ev_ga
);
  localparam int DLW = $clog2(FLAG_DLY + 1);
  localparam int BCW = $clog2(BYTE_W);

  logic [2:0]          ones;
  logic                in_sync, flag_last;
  logic [FLAG_DLY-1:0] dl;
  logic [DLW-1:0]      dl_n;
  logic [BYTE_W-1:0]   sh;
  logic [BCW-1:0]      bcnt;
  bit_kind_e           kind;
  logic                emit, e_bit;

  always_comb begin
    kind = K_NONE;
    if (bit_en) begin
      if (bit_in) begin
        if (ones == 3'd6)     kind = K_ABORT;
        else if (ones < 3'd6) kind = K_PUSH;
      end else begin
        if (ones == 3'd6)      kind = K_FLAG;
        else if (ones != 3'd5) kind = K_PUSH;   // ones == 5: inserted zero
      end
    end
    emit  = (kind == K_PUSH) && (dl_n == DLW'(FLAG_DLY));
    e_bit = dl[FLAG_DLY-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones <= '0; in_sync <= 1'b0; flag_last <= 1'b0;
      dl <= '0; dl_n <= '0; sh <= '0; bcnt <= '0;
      ev_byte <= 1'b0; ev_data <= '0; ev_flag <= 1'b0;
      ev_misalign <= 1'b0; ev_abort <= 1'b0; ev_ga <= 1'b0;
    end else begin
      ev_byte <= 1'b0; ev_flag <= 1'b0; ev_abort <= 1'b0; ev_ga <= 1'b0;
      ev_misalign <= 1'b0;
      if (bit_en) begin
        if (!bit_in)           ones <= '0;
        else if (ones != 3'd7) ones <= ones + 3'd1;
        if (!bit_in) flag_last <= 1'b0;
      end
      unique case (kind)
        K_PUSH: begin
          dl <= {dl[FLAG_DLY-2:0], bit_in};
          if (!emit) dl_n <= dl_n + DLW'(1);
          if (emit && in_sync) begin
            sh   <= {e_bit, sh[BYTE_W-1:1]};
            bcnt <= bcnt + BCW'(1);
            if (bcnt == BCW'(BYTE_W - 1)) begin
              ev_byte <= 1'b1;
              ev_data <= {e_bit, sh[BYTE_W-1:1]};
            end
          end
        end
        K_FLAG: begin
          ev_flag     <= 1'b1;
          ev_misalign <= (bcnt != '0);
          in_sync     <= 1'b1;
          flag_last   <= 1'b1;
          dl_n <= '0; bcnt <= '0;
        end
        K_ABORT: begin
          ev_abort  <= in_sync;
          ev_ga     <= flag_last;
          in_sync   <= 1'b0;
          flag_last <= 1'b0;
          dl_n <= '0; bcnt <= '0;
        end
        default: ;
      endcase
    end
  end

  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_byte, ev_flag, ev_abort}));
  p_abort_hunts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |-> !in_sync);
endmodule

// File: rtl/hdlc_rx_pktctl.sv
module hdlc_rx_pktctl
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] ev_data,
  input  logic              ev_flag,
  input  logic              ev_misalign,
  input  logic              ev_abort,
  input  logic              cfg_addr_en,
  input  logic [BYTE_W-1:0] cfg_addr,
  input  logic              q_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic              irq_pkt,
  output logic              irq_ovf
);
  localparam int HOLD = 3;   // newest byte at index 0; two of them are the check sequence

  logic [BYTE_W-1:0] hold [HOLD];
  logic [1:0]        cnt;
  logic              first_pend, drop;
  logic [15:0]       crc;
  logic              want, ovf, is_end, good;
  tag_e              tag;
  logic [BYTE_W-1:0] oldest, wdat;

  always_comb begin
    is_end = ev_flag || ev_abort;
    case (cnt)
      2'd1:    oldest = hold[0];
      2'd2:    oldest = hold[1];
      default: oldest = hold[2];
    endcase
    good = ev_flag && !ev_misalign && (cnt == 2'd3) && (crc == CRC_GOOD);
    want = 1'b0; tag = TAG_MID; wdat = hold[2];
    if (ev_byte && cnt == 2'd3) begin
      want = !drop;
      tag  = first_pend ? TAG_FIRST : TAG_MID;
    end else if (is_end && cnt != 2'd0) begin
      want = !drop;
      wdat = oldest;
      tag  = good ? TAG_GOOD : TAG_BAD;
    end
    wr_en   = want && !q_full;
    ovf     = want && q_full;
    wr_word = {tag, wdat};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HOLD; i++) hold[i] <= '0;
      cnt <= '0; first_pend <= 1'b0; drop <= 1'b0; crc <= CRC_PRESET;
      irq_pkt <= 1'b0; irq_ovf <= 1'b0;
    end else begin
      irq_pkt <= wr_en && wr_word[WORD_W-1];
      irq_ovf <= ovf;
      if (ev_byte) begin
        hold[0] <= ev_data;
        for (int i = 1; i < HOLD; i++) hold[i] <= hold[i-1];
        crc <= crc_step((cnt == 2'd0) ? CRC_PRESET : crc, ev_data);
        if (cnt != 2'd3) cnt <= cnt + 2'd1;
        if (cnt == 2'd0) begin
          first_pend <= 1'b1;
          drop       <= cfg_addr_en && (ev_data != cfg_addr);
        end
        if (cnt == 2'd3) first_pend <= 1'b0;
        if (ovf) drop <= 1'b1;
      end else if (is_end) begin
        cnt <= '0; drop <= 1'b0; first_pend <= 1'b0;
      end
    end
  end

  p_body_on_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word[WORD_W-1]) |-> ev_byte);
  p_last_on_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word[WORD_W-1]) |-> (ev_flag || ev_abort));
endmodule

// File: rtl/hdlc_rx_queue.sv
module hdlc_rx_queue
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic              full,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_word
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wp, rp;

  assign full     = (wp ^ rp) == {1'b1, {AW{1'b0}}};
  assign rd_valid = (wp != rp);
  assign rd_word  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0;
    end else begin
      if (wr_en && !full)      wp <= wp + (AW+1)'(1);
      if (rd_valid && rd_ready) rp <= rp + (AW+1)'(1);
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_word)));
endmodule

// File: rtl/hdlc_rx_tagq.sv
module hdlc_rx_tagq
  import hdlc_rx_pkg::*;
#(
  parameter int Q_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_en,
  input  logic              cfg_addr_en,
  input  logic [BYTE_W-1:0] cfg_addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_stat,
  output logic              irq_pkt,
  output logic              irq_ovf,
  output logic              ga_pulse
);
  logic              ev_byte, ev_flag, ev_misalign, ev_abort;
  logic [BYTE_W-1:0] ev_data;
  logic              wr_en, q_full;
  logic [WORD_W-1:0] wr_word, rd_word;

  hdlc_rx_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
    .ev_byte(ev_byte), .ev_data(ev_data), .ev_flag(ev_flag),
    .ev_misalign(ev_misalign), .ev_abort(ev_abort), .ev_ga(ga_pulse)
  );

  hdlc_rx_pktctl u_pktctl (
    .clk(clk), .rst_n(rst_n), .ev_byte(ev_byte), .ev_data(ev_data),
    .ev_flag(ev_flag), .ev_misalign(ev_misalign), .ev_abort(ev_abort),
    .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr), .q_full(q_full),
    .wr_en(wr_en), .wr_word(wr_word), .irq_pkt(irq_pkt), .irq_ovf(irq_ovf)
  );

  hdlc_rx_queue #(.DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .full(q_full),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_word(rd_word)
  );

  assign rd_data = rd_word[BYTE_W-1:0];
  assign rd_stat = rd_word[WORD_W-1:BYTE_W];

  p_ovf_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> $past(q_full));
  p_irq_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word[WORD_W-1]) |=> irq_pkt);
endmodule

// File: tb/hdlc_rx_tagq_tb.sv
module hdlc_rx_tagq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0, bit_en = 1'b0, cfg_addr_en = 1'b0, rd_ready = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic rd_valid, irq_pkt, irq_ovf, ga_pulse;
  logic [7:0] rd_data;
  logic [1:0] rd_stat;

  int n_run = 0, n_fail = 0, ones_run = 0;
  int pkt_cnt = 0, ovf_cnt = 0, ga_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  hdlc_rx_tagq u_dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
    .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_stat(rd_stat),
    .irq_pkt(irq_pkt), .irq_ovf(irq_ovf), .ga_pulse(ga_pulse)
  );

  always @(posedge clk) begin
    if (irq_pkt)  pkt_cnt++;
    if (irq_ovf)  ovf_cnt++;
    if (ga_pulse) ga_cnt++;
  end

  typedef struct packed { logic [7:0] n; logic [7:0] seed; logic bad; } vec_t;
  localparam vec_t VT [6] = '{
    '{8'd1, 8'h11, 1'b0}, '{8'd3, 8'hA0, 1'b0}, '{8'd6, 8'h7E, 1'b0},
    '{8'd4, 8'hFF, 1'b0}, '{8'd5, 8'h3C, 1'b1}, '{8'd2, 8'hFC, 1'b1}
  };

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
    return seed ^ (8'(i) * 8'h11);
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tx_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      tx_bit(b[i]);
      if (b[i]) ones_run++; else ones_run = 0;
      if (ones_run == 5) begin tx_bit(1'b0); ones_run = 0; end
    end
  endtask

  task automatic tx_flag();
    tx_bit(1'b0);
    for (int i = 0; i < 6; i++) tx_bit(1'b1);
    tx_bit(1'b0);
    ones_run = 0;
  endtask

  task automatic tx_frame(input int n, input logic [7:0] seed, input bit bad, input bit close);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    tx_flag();
    for (int i = 0; i < n; i++) begin
      tx_byte(dbyte(seed, i));
      c = ref_crc(c, dbyte(seed, i));
    end
    fcs = ~c;
    if (bad) fcs[0] = ~fcs[0];
    if (close) begin
      tx_byte(fcs[7:0]);
      tx_byte(fcs[15:8]);
      tx_flag();
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic pop_expect(input logic [7:0] ed, input logic [1:0] es, input string req);
    @(negedge clk);
    check(rd_valid == 1'b1, req, rd_valid, 1);
    check({rd_stat, rd_data} == {es, ed}, req, {rd_stat, rd_data}, {es, ed});
    rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    check(rd_valid == 1'b0, req, rd_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] es;
    logic [7:0] w_a, w_b;
    int base;
    repeat (4) @(negedge clk);
    // R12: reset state
    check({rd_valid, irq_pkt, irq_ovf, ga_pulse} == 4'b0, "R12", {rd_valid, irq_pkt, irq_ovf, ga_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: bytes before the first flag are ignored
    tx_byte(8'h55); tx_byte(8'hA5);
    settle(); expect_empty("R1");

    // Table walk: R2 R3 R4 R5 R11
    foreach (VT[v]) begin
      base = pkt_cnt;
      tx_frame(int'(VT[v].n), VT[v].seed, VT[v].bad, 1'b1);
      settle();
      for (int i = 0; i < int'(VT[v].n); i++) begin
        if (i == int'(VT[v].n) - 1) es = VT[v].bad ? 2'b11 : 2'b10;
        else if (i == 0)            es = 2'b01;
        else                        es = 2'b00;
        pop_expect(dbyte(VT[v].seed, i), es, VT[v].bad ? "R5 table" : "R4 table");
      end
      expect_empty("R4 fcs not stored");
      check(pkt_cnt == base + 1, "R11", pkt_cnt - base, 1);
    end
    check(ga_cnt == 0, "R7 no go-ahead on normal traffic", ga_cnt, 0);

    // R10: back-pressure holds the head word
    tx_frame(3, 8'h42, 1'b0, 1'b1);
    settle();
    @(negedge clk); w_a = rd_data;
    repeat (3) @(negedge clk); w_b = rd_data;
    check(rd_valid && (w_a == w_b) && (w_a == 8'h42), "R10", w_b, 8'h42);
    pop_expect(8'h42, 2'b01, "R10");
    pop_expect(dbyte(8'h42, 1), 2'b00, "R10");
    pop_expect(dbyte(8'h42, 2), 2'b10, "R10");

    // R6: abort mid-packet, then no resync without a flag
    tx_flag();
    tx_byte(8'h10); tx_byte(8'h21); tx_byte(8'h32); tx_byte(8'h43); tx_byte(8'h00);
    for (int i = 0; i < 7; i++) tx_bit(1'b1);
    ones_run = 0;
    tx_bit(1'b0);
    settle();
    pop_expect(8'h10, 2'b01, "R6");
    pop_expect(8'h21, 2'b11, "R6");
    expect_empty("R6");
    tx_byte(8'h55); tx_byte(8'h55); tx_byte(8'h55);
    settle(); expect_empty("R1 after abort");

    // R5: closing flag off a byte boundary
    tx_flag();
    tx_byte(8'h61); tx_byte(8'h72); tx_byte(8'h83); tx_byte(8'h94);
    tx_bit(1'b0); tx_bit(1'b0); tx_bit(1'b0); ones_run = 0;
    tx_flag();
    settle();
    pop_expect(8'h61, 2'b01, "R5 misaligned");
    pop_expect(8'h72, 2'b11, "R5 misaligned");

    // R7: go-ahead right after a flag
    base = ga_cnt;
    tx_flag();
    for (int i = 0; i < 7; i++) tx_bit(1'b1);
    ones_run = 0;
    tx_bit(1'b0);
    settle();
    check(ga_cnt == base + 1, "R7", ga_cnt - base, 1);
    expect_empty("R7");

    // R8: address filter
    cfg_addr_en = 1'b1; cfg_addr = 8'h31;
    tx_frame(3, 8'h30, 1'b0, 1'b1);
    settle(); expect_empty("R8 mismatch dropped");
    tx_frame(2, 8'h31, 1'b0, 1'b1);
    settle();
    pop_expect(8'h31, 2'b01, "R8 match");
    pop_expect(dbyte(8'h31, 1), 2'b10, "R8 match");
    cfg_addr_en = 1'b0;

    // R9: overflow discards rest of the packet
    base = pkt_cnt;
    tx_frame(20, 8'h05, 1'b0, 1'b1);
    settle();
    check(ovf_cnt == 1, "R9 irq", ovf_cnt, 1);
    check(pkt_cnt == base, "R9 no end word", pkt_cnt - base, 0);
    for (int i = 0; i < 16; i++)
      pop_expect(dbyte(8'h05, i), (i == 0) ? 2'b01 : 2'b00, "R9");
    expect_empty("R9 rest dropped");
    tx_frame(2, 8'h77, 1'b0, 1'b1);
    settle();
    pop_expect(8'h77, 2'b01, "R9 recovery");
    pop_expect(dbyte(8'h77, 1), 2'b10, "R9 recovery");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule